// File: doc/BRIEF.md
# Debug Authentication Enable Synchronizer

This block takes four debug-authentication enables that arrive from outside the clock domain and passes each one through its own synchronizer. It derives four permission bits from the synchronized enables. Software can read these bits through a status port and poll them until a change it requested shows up. The bits appear only once the new enable value has actually been captured, which may be several cycles after the system drove it.

A second copy of the permissions drives the debug logic. This effective copy does not follow the inputs on its own. It takes the currently synchronized permissions only on a context synchronization strobe, which marks an instruction barrier, an exception entry or an exception return. The same strobe is used when the core is halted and its instructions come from the debugger's instruction-transfer path. Software therefore changes the enables, polls status until the new value appears, and then issues a barrier so that the debug logic adopts it.

Top module: `dbg_auth_sync`

## Requirements
- R1: After reset, the effective permissions are 0, the read data is all zero and the read-valid output is low, meaning all debug is disabled.
- R2: The enable bus is defined as follows: bit 0 is invasive, bit 1 is non-invasive, bit 2 is secure invasive and bit 3 is secure non-invasive. Four permission bits are derived from it:
  - secure-invasive = inv & sinv
  - invasive = inv
  - secure-non-invasive = (inv | ninv) & (sinv | sninv)
  - non-invasive = inv | ninv

  In the read data these are bits 17, 16, 15 and 14, in that order, and every other bit reads 0.
- R3: After an enable changes ahead of rising edge 1, a read sampled on rising edge 2 still returns the old permissions, and a read sampled on rising edge 3 returns the new ones.
- R4: While the sync strobe stays low, the effective permissions hold their value whatever the enables do.
- R5: When the sync strobe is high on a rising edge, the effective permissions (bits 3 to 0 = secure-invasive, invasive, secure-non-invasive, non-invasive) take the synchronized permissions present before that edge.
- R6: A sync strobe on rising edge 2 after an enable change loads the old permissions, and a strobe on rising edge 3 loads the new ones.
- R7: The read-valid output is high in the cycle after each cycle in which the read request is high, and low otherwise. A run of consecutive requests keeps it high.
- R8: When no read is requested, the read data holds its last value even if the enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auth_en_a | input | 4 | Asynchronous enables: [0] invasive, [1] non-invasive, [2] secure invasive, [3] secure non-invasive |
| ctx_sync_i | input | 1 | Single-cycle context synchronization strobe |
| rd_en_i | input | 1 | Status read request |
| rd_data_o | output | 32 | Status word returned for a read, permissions in [17:14] |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| eff_perm_o | output | 4 | Effective permissions: [3] secure invasive, [2] invasive, [1] secure non-invasive, [0] non-invasive |

## Verification
The hardest situation to reach from the ports is an enable change still in flight in the synchronizer while a barrier strobe or a status read lands. In that case the effective copy must take the old value, not the raw input. The bench drives a new enable pattern on a falling edge and then places the strobe and the read on exactly the second and third rising edges that follow. This shows which edge first makes the new value observable. It also walks all sixteen enable combinations to cover the permission encoding.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;

    localparam int AUTH_N = 4;
    localparam int PERM_N = 4;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RESP = 2'd1
    } rd_state_e;

    typedef struct packed {
        logic sec_inv;
        logic inv;
        logic sec_ninv;
        logic ninv;
    } perm_t;

    function automatic perm_t auth_to_perm(input logic [AUTH_N-1:0] en);
        perm_t p;
        p.inv      = en[0];
        p.ninv     = en[0] | en[1];
        p.sec_inv  = en[0] & en[2];
        p.sec_ninv = (en[0] | en[1]) & (en[2] | en[3]);
        return p;
    endfunction

endpackage

// File: rtl/dbg_auth_sync_cell.sv
module dbg_auth_sync_cell #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else if (STAGES == 1) begin
                chain <= d_a[b];
            end else begin
                chain <= {chain[STAGES-2:0], d_a[b]};
            end
        end

        assign q[b] = chain[LAST];
    end
endmodule

// File: rtl/dbg_auth_eff_reg.sv
module dbg_auth_eff_reg
    import dbg_auth_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  perm_t perm_i,
    output perm_t perm_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_o <= '0;
        end else if (load_i) begin
            perm_o <= perm_i;
        end
    end
endmodule

// File: rtl/dbg_auth_stat_port.sv
module dbg_auth_stat_port
    import dbg_auth_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int STAT_LSB = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  perm_t             perm_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    localparam int STAT_MSB = STAT_LSB + PERM_N - 1;

    rd_state_e state_q, state_d;
    logic [STAT_W-1:0] word;

    always_comb begin
        word = '0;
        word[STAT_MSB:STAT_LSB] = perm_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: IDLE->RESP on request, RESP->RESP on request, RESP->IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en_i) state_d = RD_RESP;
            RD_RESP: if (!rd_en_i) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= word;
        end
    end

    assign rd_valid_o = (state_q == RD_RESP);
endmodule

// File: rtl/dbg_auth_sync.sv
module dbg_auth_sync
    import dbg_auth_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STAT_W      = 32,
    parameter int STAT_LSB    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        auth_en_a,
    input  logic              ctx_sync_i,
    input  logic              rd_en_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic [3:0]        eff_perm_o
);
    logic [AUTH_N-1:0] en_sync;
    perm_t             perm_now;
    perm_t             perm_eff;

    dbg_auth_sync_cell #(.W(AUTH_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (auth_en_a),
        .q     (en_sync)
    );

    assign perm_now = auth_to_perm(en_sync);

    dbg_auth_eff_reg u_eff (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctx_sync_i),
        .perm_i (perm_now),
        .perm_o (perm_eff)
    );

    dbg_auth_stat_port #(.STAT_W(STAT_W), .STAT_LSB(STAT_LSB)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .perm_i     (perm_now),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    assign eff_perm_o = perm_eff;
endmodule

// File: rtl/dbg_auth_sync_chk.sv
module dbg_auth_sync_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctx_sync_i,
    input logic              rd_en_i,
    input logic [STAT_W-1:0] rd_data_o,
    input logic              rd_valid_o,
    input logic [3:0]        eff_perm_o,
    input logic [3:0]        perm_now
);
    assert_eff_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_sync_i |=> $stable(eff_perm_o));

    assert_eff_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_sync_i |=> eff_perm_o == $past(perm_now));

    assert_valid_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    assert_valid_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    assert_inv_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !(rd_data_o[17] && !rd_data_o[16]) && !(rd_data_o[15] && !rd_data_o[14]));

    assert_zero_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o & ~(32'hF << 14)) == '0);
endmodule

bind dbg_auth_sync dbg_auth_sync_chk #(.STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctx_sync_i (ctx_sync_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .eff_perm_o (eff_perm_o),
    .perm_now   (perm_now)
);

// File: tb/sim_dbg_auth_sync.sv
`timescale 1ns/1ps
module sim_dbg_auth_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  auth_en_a = '0;
    logic        ctx_sync_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        rd_valid_o;
    logic [3:0]  eff_perm_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbg_auth_sync u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .auth_en_a  (auth_en_a),
        .ctx_sync_i (ctx_sync_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .eff_perm_o (eff_perm_o)
    );

    function automatic logic [3:0] exp_perm(input logic [3:0] en);
        logic i, n, s, sn;
        i = en[0]; n = en[1]; s = en[2]; sn = en[3];
        return {i & s, i, (i | n) & (s | sn), i | n};
    endfunction

    function automatic logic [31:0] exp_word(input logic [3:0] en);
        return {14'd0, exp_perm(en), 14'd0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one read request; returns with data sampled at a falling edge
    task automatic do_read(output logic [31:0] data, output logic vld);
        @(negedge clk) rd_en_i = 1'b1;
        @(negedge clk) rd_en_i = 1'b0;
        data = rd_data_o;
        vld  = rd_valid_o;
    endtask

    task automatic pulse_sync();
        @(negedge clk) ctx_sync_i = 1'b1;
        @(negedge clk) ctx_sync_i = 1'b0;
    endtask

    task automatic set_en_settle(input logic [3:0] en);
        @(negedge clk) auth_en_a = en;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 eff", {28'd0, eff_perm_o}, 32'd0);
        check("R1 data", rd_data_o, 32'd0);
        check("R1 valid", {31'd0, rd_valid_o}, 32'd0);
    endtask

    task automatic t_encoding();
        logic [31:0] d;
        logic v;
        for (int k = 0; k < 16; k++) begin
            set_en_settle(k[3:0]);
            do_read(d, v);
            check("R2 word", d, exp_word(k[3:0]));
            check("R7 valid", {31'd0, v}, 32'd1);
            pulse_sync();
            check("R5 eff", {28'd0, eff_perm_o}, {28'd0, exp_perm(k[3:0])});
        end
    endtask

    task automatic t_latency();
        set_en_settle(4'h0);
        @(negedge clk) auth_en_a = 4'h5;     // change ahead of edge 1
        @(negedge clk) rd_en_i = 1'b1;       // read sampled at edge 2
        @(negedge clk);
        check("R3 edge2 old", rd_data_o, exp_word(4'h0));
        @(negedge clk) rd_en_i = 1'b0;       // edge 3 sampled the read
        check("R3 edge3 new", rd_data_o, exp_word(4'h5));
        check("R7 run valid", {31'd0, rd_valid_o}, 32'd1);
        @(negedge clk);
        check("R7 valid drop", {31'd0, rd_valid_o}, 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        logic v;
        set_en_settle(4'hF);
        pulse_sync();
        check("R4 base", {28'd0, eff_perm_o}, 32'hF);
        set_en_settle(4'h0);
        repeat (3) @(negedge clk);
        check("R4 eff held", {28'd0, eff_perm_o}, 32'hF);
        check("R8 data held", rd_data_o, exp_word(4'h5));
        do_read(d, v);
        check("R2 zero perms", d, 32'd0);
        pulse_sync();
        check("R5 eff cleared", {28'd0, eff_perm_o}, 32'd0);
    endtask

    task automatic t_race();
        set_en_settle(4'h2);
        pulse_sync();
        @(negedge clk) auth_en_a = 4'hD;     // edge 1 follows
        @(negedge clk) ctx_sync_i = 1'b1;    // strobe on edge 2
        @(negedge clk);
        check("R6 edge2 old", {28'd0, eff_perm_o}, {28'd0, exp_perm(4'h2)});
        @(negedge clk) ctx_sync_i = 1'b0;    // strobe also on edge 3
        check("R6 edge3 new", {28'd0, eff_perm_o}, {28'd0, exp_perm(4'hD)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_encoding();
        t_latency();
        t_hold();
        t_race();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule